// File: doc/BRIEF.md
# Bus Bridge Address Window Decoder

This block sits in the downstream path of a bus bridge. For every request arriving from the host-side system bus it decides whether the 32-bit address belongs to one of two I/O-side ports. It also decides what address goes out on that port. Each port owns one address window. A window is described by a lower bound register, which carries a segment tag and a starting page, and an upper bound register, which carries the end page. A two-bit forwarding mode chooses between three behaviours. In the first, window addresses are ignored. In the second, they are passed through unchanged. In the third, short writes are remapped into the broadcast space by forcing the upper address bits to ones.

Software or a bridge controller programs the bound registers and the mode through a small write port. The write port uses an index and a strobe. A request is presented with a valid pulse, its address and a write-short qualifier. Exactly one cycle later a response appears. The response carries the hit flag, the chosen port and the outgoing address.

Top module: `iowin_decoder`

## Requirements
- R1: After reset the mode is Off (0) and all bound registers are zero; a request that lies inside a window programmed after reset, with the mode left untouched, reports a miss.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, whether the request hits or not, and `rsp_hit` is never high without `rsp_valid`.
- R3: A window can hit only when address bits [31:24] are all ones.
- R4: A window can hit only when address bits [23:20] equal bits [15:12] of that window's lower bound register.
- R5: A window can hit only when address bits [19:8] are at least lower bound bits [11:0] and strictly below upper bound bits [11:0].
- R6: A window whose lower page field is equal to or greater than its upper page field never hits.
- R7: In Off mode (0), and with the undefined encoding 2, a request inside a window reports a miss.
- R8: In Include mode (1), a hitting request is forwarded with its address unchanged, and `rsp_port` gives the index of the matching window.
- R9: In Peek mode (3), a hitting write-short request is forwarded with address bits [31:18] forced to ones and bits [17:0] unchanged; a request without write-short reports a miss.
- R10: When both windows match, the response names port 0.
- R11: A write with `cfg_we` loads the register selected by `cfg_addr`: index 0 holds the mode in `cfg_wdata[1:0]`, 2 and 3 hold the lower bound and the upper page of window 0, and 4 and 5 hold the same for window 1. A request in the same cycle as a write is decoded with the old register contents.
- R12: A miss response carries `rsp_port` = 0 and `rsp_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 16 | Register write data |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request address |
| req_wshort | input | 1 | Request is a short write |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Request is forwarded |
| rsp_port | output | 1 | Target I/O-side port |
| rsp_addr | output | 32 | Outgoing address, zero on a miss |

## Verification
The assertions compare the response with the address and the write-short flag of the previous cycle. They therefore assume that both request inputs carry known values whenever `req_valid` is high, and that these values stay steady across the sampling edge. The bench changes every input only on the falling clock edge and always drives fully defined values. When no request is active it parks the request fields at zero. Each check is placed after the single register stage, so every sampled response belongs to exactly one request.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  typedef enum logic [1:0] {
    FWD_OFF     = 2'd0,
    FWD_INCLUDE = 2'd1,
    FWD_RSVD    = 2'd2,
    FWD_PEEK    = 2'd3
  } fwd_mode_e;

  // register index map: mode, then lower/upper pairs per window
  localparam int CFG_MODE_IDX = 0;
  localparam int CFG_WIN_BASE = 2;

  function automatic int lo_index(input int w);
    return CFG_WIN_BASE + 2 * w;
  endfunction

  function automatic int hi_index(input int w);
    return CFG_WIN_BASE + 2 * w + 1;
  endfunction

endpackage

// File: rtl/iowin_cfg_regs.sv
module iowin_cfg_regs
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int SEG_W   = 4,
  parameter int PAGE_W  = 12,
  parameter int CFG_AW  = 3,
  parameter int BND_W   = SEG_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [BND_W-1:0]  cfg_wdata,
  output fwd_mode_e         mode_q,
  output logic [BND_W-1:0]  lo_q [NUM_WIN],
  output logic [PAGE_W-1:0] hi_q [NUM_WIN]
);

  logic      mode_en;
  fwd_mode_e mode_d;

  always_comb begin
    mode_en = cfg_we && (cfg_addr == CFG_AW'(CFG_MODE_IDX));
    mode_d  = fwd_mode_e'(cfg_wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= FWD_OFF;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic              lo_en;
    logic              hi_en;
    logic [BND_W-1:0]  lo_d;
    logic [PAGE_W-1:0] hi_d;

    always_comb begin
      lo_en = cfg_we && (cfg_addr == CFG_AW'(lo_index(w)));
      hi_en = cfg_we && (cfg_addr == CFG_AW'(hi_index(w)));
      lo_d  = cfg_wdata;
      hi_d  = cfg_wdata[PAGE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[w] <= '0;
      end else if (lo_en) begin
        lo_q[w] <= lo_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[w] <= '0;
      end else if (hi_en) begin
        hi_q[w] <= hi_d;
      end
    end
  end

endmodule

// File: rtl/iowin_window_match.sv
module iowin_window_match #(
  parameter int PREFIX_W = 8,
  parameter int SEG_W    = 4,
  parameter int PAGE_W   = 12,
  parameter int BND_W    = SEG_W + PAGE_W,
  parameter int TAG_W    = PREFIX_W + SEG_W + PAGE_W
) (
  input  logic [TAG_W-1:0]  tag,
  input  logic [BND_W-1:0]  lo,
  input  logic [PAGE_W-1:0] hi,
  output logic              hit
);

  logic [PREFIX_W-1:0] prefix;
  logic [SEG_W-1:0]    seg;
  logic [PAGE_W-1:0]   page;
  logic [SEG_W-1:0]    lo_seg;
  logic [PAGE_W-1:0]   lo_page;
  logic                prefix_ok;
  logic                seg_ok;
  logic                range_ok;
  logic                win_on;

  always_comb begin
    prefix    = tag[TAG_W-1 -: PREFIX_W];
    seg       = tag[SEG_W+PAGE_W-1 -: SEG_W];
    page      = tag[PAGE_W-1:0];
    lo_seg    = lo[BND_W-1 -: SEG_W];
    lo_page   = lo[PAGE_W-1:0];
    prefix_ok = &prefix;
    seg_ok    = (seg == lo_seg);
    range_ok  = (page >= lo_page) && (page < hi);
    win_on    = (lo_page < hi);
    hit       = prefix_ok && seg_ok && range_ok && win_on;
  end

endmodule

// File: rtl/iowin_forward.sv
module iowin_forward
  import iowin_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2,
  parameter int BCAST_W = 14,
  parameter int PORT_W  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_wshort,
  input  fwd_mode_e          mode,
  input  logic [NUM_WIN-1:0] win_hit,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [PORT_W-1:0]  rsp_port,
  output logic [ADDR_W-1:0]  rsp_addr
);

  logic [PORT_W-1:0] sel_port;
  logic              any_hit;
  logic              allow;
  logic [ADDR_W-1:0] fwd_addr;
  logic              hit_d;
  logic [PORT_W-1:0] port_d;
  logic [ADDR_W-1:0] addr_d;
  logic              rsp_en;

  // lowest window index wins
  always_comb begin
    sel_port = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (win_hit[w]) sel_port = PORT_W'(w);
    end
    any_hit = |win_hit;
  end

  always_comb begin
    allow    = 1'b0;
    fwd_addr = req_addr;
    unique case (mode)
      FWD_INCLUDE: allow = 1'b1;
      FWD_PEEK: begin
        allow    = req_wshort;
        fwd_addr = {{BCAST_W{1'b1}}, req_addr[ADDR_W-BCAST_W-1:0]};
      end
      default: allow = 1'b0;
    endcase
  end

  always_comb begin
    hit_d  = req_valid && any_hit && allow;
    port_d = hit_d ? sel_port : '0;
    addr_d = hit_d ? fwd_addr : '0;
    rsp_en = req_valid || rsp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_port  <= '0;
      rsp_addr  <= '0;
    end else if (rsp_en) begin
      rsp_valid <= req_valid;
      rsp_hit   <= hit_d;
      rsp_port  <= port_d;
      rsp_addr  <= addr_d;
    end
  end

endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
  import iowin_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PREFIX_W = 8,
  parameter int SEG_W    = 4,
  parameter int PAGE_W   = 12,
  parameter int NUM_WIN  = 2,
  parameter int BCAST_W  = 14,
  parameter int CFG_AW   = 3,
  parameter int BND_W    = SEG_W + PAGE_W,
  parameter int PORT_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [BND_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wshort,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PORT_W-1:0] rsp_port,
  output logic [ADDR_W-1:0] rsp_addr
);

  localparam int TAG_W = PREFIX_W + SEG_W + PAGE_W;

  fwd_mode_e          mode_q;
  logic [BND_W-1:0]   lo_q [NUM_WIN];
  logic [PAGE_W-1:0]  hi_q [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit;
  logic [TAG_W-1:0]   req_tag;

  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

  iowin_cfg_regs #(
    .NUM_WIN (NUM_WIN),
    .SEG_W   (SEG_W),
    .PAGE_W  (PAGE_W),
    .CFG_AW  (CFG_AW),
    .BND_W   (BND_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .mode_q    (mode_q),
    .lo_q      (lo_q),
    .hi_q      (hi_q)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    iowin_window_match #(
      .PREFIX_W (PREFIX_W),
      .SEG_W    (SEG_W),
      .PAGE_W   (PAGE_W),
      .BND_W    (BND_W),
      .TAG_W    (TAG_W)
    ) u_match (
      .tag (req_tag),
      .lo  (lo_q[w]),
      .hi  (hi_q[w]),
      .hit (win_hit[w])
    );
  end

  iowin_forward #(
    .ADDR_W  (ADDR_W),
    .NUM_WIN (NUM_WIN),
    .BCAST_W (BCAST_W),
    .PORT_W  (PORT_W)
  ) u_fwd (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_wshort (req_wshort),
    .mode       (mode_q),
    .win_hit    (win_hit),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_port   (rsp_port),
    .rsp_addr   (rsp_addr)
  );

endmodule

// File: rtl/iowin_decoder_chk.sv
module iowin_decoder_chk #(
  parameter int ADDR_W   = 32,
  parameter int PREFIX_W = 8,
  parameter int BCAST_W  = 14,
  parameter int PORT_W   = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_wshort,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [PORT_W-1:0] rsp_port,
  input logic [ADDR_W-1:0] rsp_addr
);

  localparam int KEEP_W = ADDR_W - BCAST_W;

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2

  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit); // R2

  AST_HIT_PREFIX_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (&rsp_addr[ADDR_W-1 -: PREFIX_W])); // R3

  AST_HIT_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_addr[KEEP_W-1:0] == $past(req_addr[KEEP_W-1:0]))); // R8

  AST_PLAIN_HIT_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !$past(req_wshort)) |-> (rsp_addr == $past(req_addr))); // R9

  AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && rsp_port == '0)); // R12

endmodule

bind iowin_decoder iowin_decoder_chk #(
  .ADDR_W   (ADDR_W),
  .PREFIX_W (PREFIX_W),
  .BCAST_W  (BCAST_W),
  .PORT_W   (PORT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .req_wshort (req_wshort),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_port   (rsp_port),
  .rsp_addr   (rsp_addr)
);

// File: tb/iowin_decoder_test.sv
`timescale 1ns/1ps
module iowin_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_wshort;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [0:0]  rsp_port;
  logic [31:0] rsp_addr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // bench-side model of the programmed registers
  logic [1:0]  m_mode;
  logic [15:0] m_lo [2];
  logic [11:0] m_hi [2];

  always #2.5 clk = ~clk;

  iowin_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_wshort(req_wshort), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_port(rsp_port), .rsp_addr(rsp_addr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit win_match(input int w, input logic [31:0] a);
    return (a[31:24] == 8'hFF) && (a[23:20] == m_lo[w][15:12]) &&
           (a[19:8] >= m_lo[w][11:0]) && (a[19:8] < m_hi[w]);
  endfunction

  task automatic expect_of(input logic [31:0] a, input bit ws, output bit hit,
                           output bit port, output logic [31:0] oa);
    bit m0 = win_match(0, a);
    bit m1 = win_match(1, a);
    bit ok = (m_mode == 2'd1) || (m_mode == 2'd3 && ws);
    hit  = (m0 || m1) && ok;
    port = hit && !m0;
    oa   = !hit ? 32'h0 : (m_mode == 2'd3) ? {14'h3FFF, a[17:0]} : a;
  endtask

  task automatic cfg_write(input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    case (idx)
      3'd0: m_mode = d[1:0];
      3'd2: m_lo[0] = d;
      3'd3: m_hi[0] = d[11:0];
      3'd4: m_lo[1] = d;
      3'd5: m_hi[1] = d[11:0];
      default: ;
    endcase
  endtask

  task automatic send(input logic [31:0] a, input bit ws, input string req);
    bit e_hit, e_port;
    logic [31:0] e_addr;
    expect_of(a, ws, e_hit, e_port, e_addr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_wshort = ws;
    @(negedge clk);
    req_valid = 1'b0; req_addr = '0; req_wshort = 1'b0;
    check(rsp_valid == 1'b1, "R2 valid", {31'b0, rsp_valid}, 32'h1);
    check(rsp_hit == e_hit, {req, " hit"}, {31'b0, rsp_hit}, {31'b0, e_hit});
    check(rsp_port == e_port, {req, " port"}, {31'b0, rsp_port}, {31'b0, e_port});
    check(rsp_addr == e_addr, {req, " addr"}, rsp_addr, e_addr);
  endtask

  task automatic setup_windows();
    cfg_write(3'd2, 16'h3100); cfg_write(3'd3, 16'h0200);
    cfg_write(3'd4, 16'h3180); cfg_write(3'd5, 16'h0300);
  endtask

  task automatic t_reset();
    check(rsp_valid == 0 && rsp_hit == 0 && rsp_addr == 0, "R1 reset outputs",
          rsp_addr, 32'h0);
    setup_windows();
    send(32'hFF315012, 1'b0, "R1 off after reset");
  endtask

  task automatic t_off_modes();
    cfg_write(3'd0, 16'h0000);
    send(32'hFF315012, 1'b0, "R7 off");
    cfg_write(3'd0, 16'h0002);
    send(32'hFF315012, 1'b1, "R7 mode2");
  endtask

  task automatic t_include();
    cfg_write(3'd0, 16'h0001);
    send(32'hFF310012, 1'b0, "R8 port0");
    send(32'hFF325034, 1'b0, "R8 port1");
    send(32'hFF32FF01, 1'b1, "R5 top page");
    send(32'hFF330001, 1'b0, "R5 upper bound excluded");
    send(32'hFF30FF77, 1'b0, "R5 below lower");
    send(32'hFF31A055, 1'b0, "R10 overlap");
    send(32'hFE315000, 1'b0, "R3 prefix");
    send(32'h7F315000, 1'b0, "R3 prefix msb");
    send(32'hFF415000, 1'b0, "R4 segment");
    // idle cycle after the response
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2 idle", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic t_disable();
    cfg_write(3'd3, 16'h0100);
    send(32'hFF310010, 1'b0, "R6 equal bounds");
    cfg_write(3'd2, 16'h3150);
    send(32'hFF312010, 1'b0, "R6 lower above upper");
    send(32'hFF315010, 1'b0, "R6 at lower");
    setup_windows();
  endtask

  task automatic t_peek();
    cfg_write(3'd0, 16'h0003);
    send(32'hFF3150AB, 1'b1, "R9 peek short write");
    send(32'hFF3250CD, 1'b1, "R9 peek port1");
    send(32'hFF3150AB, 1'b0, "R9 peek non-short");
  endtask

  task automatic t_same_cycle();
    bit e_hit, e_port;
    logic [31:0] e_addr;
    cfg_write(3'd0, 16'h0001);
    expect_of(32'hFF315022, 1'b0, e_hit, e_port, e_addr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd3; cfg_wdata = 16'h0120;
    req_valid = 1'b1; req_addr = 32'hFF315022; req_wshort = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0;
    m_hi[0] = 12'h120;
    check(rsp_hit == e_hit && e_hit, "R11 old values", {31'b0, rsp_hit}, {31'b0, e_hit});
    check(rsp_addr == e_addr, "R11 old addr", rsp_addr, e_addr);
    send(32'hFF315022, 1'b0, "R11 new values");
    send(32'hFF311022, 1'b0, "R11 new window");
    send(32'hFF315000, 1'b0, "R12 miss fields");
  endtask

  initial begin
    cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 0; req_addr = '0; req_wshort = 0;
    m_mode = 2'd0;
    for (int w = 0; w < 2; w++) begin m_lo[w] = '0; m_hi[w] = '0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off_modes();
    t_include();
    t_disable();
    t_peek();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule